// File: doc/BRIEF.md
# Slot-Gated Store Buffer

This block is a small per-core write queue placed between a core's store path and a shared bus arbitrated by time division. A store is committed, from the core's point of view, in the cycle it is written into the queue. The core waits only when the queue is full. Queued entries leave in arrival order, at most one per cycle, and only in cycles where the arbiter marks the core's time slot as active.

There is no bus-side ready handshake. Slot ownership alone decides when the queue drains. Stores that arrive while another core owns the bus collect in the queue. When the core's slot opens they go out on consecutive cycles. A store that becomes sendable just after the slot closes waits for the core's slot in the next window.

Top module: `sbuf_tdma_drain`

## Requirements
- R1: After reset the queue is empty, `st_ready` is 1 and `bus_valid` is 0.
- R2: A store is accepted in any cycle where `st_valid` and `st_ready` are both 1. `st_ready` is 1 whenever fewer than DEPTH entries are held.
- R3: `bus_valid` is 1 only in cycles where `slot_active` is 1. In every cycle where `slot_active` is 1 and at least one entry is held at the start of the cycle, `bus_valid` is 1.
- R4: Entries leave in the order they were accepted, one per cycle, and `bus_addr`/`bus_data` carry the accepted address and data unchanged.
- R5: An entry is never sent in the cycle it is written. The earliest cycle it can be sent is the one after its acceptance.
- R6: When DEPTH entries are held, `st_ready` is 0 unless a send happens in that cycle. In that case a waiting store is accepted in the same cycle.
- R7: With the default DEPTH of 2, two stores are accepted while no slot is active, and a third one stalls.
- R8: Consider an 8-cycle window with the slot on relative cycles 0 and 1, and three stores whose presentation gaps are 4 and then 1 cycles after each previous acceptance. Starting the first store at relative cycle 0 takes 10 cycles from its acceptance to the last send. Starting it at relative cycle 1 takes 16 cycles. Every start offset matches a cycle-level model of R2 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core presents a store |
| st_ready | output | 1 | Queue can take the store this cycle |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| slot_active | input | 1 | Core owns the current bus slot |
| bus_valid | output | 1 | Oldest entry is sent this cycle |
| bus_addr | output | ADDR_W | Address of the sent entry |
| bus_data | output | DATA_W | Data of the sent entry |

## Verification
The assertions assume that the core holds a presented store's address and data until it is accepted. They also assume that `slot_active` is a clean level that changes only at clock edges. They make no assumption about slot length or window period. The bench derives `slot_active` from a registered cycle counter. It changes `st_valid` and the payload only at falling edges, and it keeps the payload steady while a store stalls. The bench sweeps all eight start offsets of the injection trace. It also runs a phase with the slot forced off, so that the full-queue stall appears with no send to free an entry.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    localparam int unsigned DEF_DEPTH  = 2;
    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_DATA_W = 32;

    function automatic int unsigned ptr_width(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction
endpackage

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
    import sbuf_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned PW = ptr_width(DEPTH),
    localparam int unsigned CW = cnt_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          slot_active,
    output logic          can_push,
    output logic          push,
    output logic          pop,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d     = st_q;
        pop      = slot_active && (st_q.cnt != '0);
        can_push = (st_q.cnt != CW'(DEPTH)) || pop;
        push     = push_req && can_push;
        if (push) st_d.wr = bump(st_q.wr);
        if (pop)  st_d.rd = bump(st_q.rd);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;
    assign count  = st_q.cnt;

    // R2: occupancy never passes the depth
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    // R6: a full queue with a waiting store and a send takes the store at once
    a_r6_refill_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CW'(DEPTH) && slot_active && push_req) |=> (st_q.cnt == CW'(DEPTH)));
endmodule

// File: rtl/sbuf_store.sv
module sbuf_store
    import sbuf_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned W     = DEF_ADDR_W + DEF_DATA_W,
    localparam int unsigned PW   = ptr_width(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] wr_ptr,
    input  logic [W-1:0]  wdata,
    input  logic [PW-1:0] rd_ptr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic [W-1:0] ent_d;
        always_comb begin
            ent_d = mem_q[i];
            if (we && (wr_ptr == PW'(i))) ent_d = wdata;
        end
        always_ff @(posedge clk) mem_q[i] <= ent_d;
    end

    assign rdata = mem_q[rd_ptr];
endmodule

// File: rtl/sbuf_tdma_drain.sv
module sbuf_tdma_drain
    import sbuf_pkg::*;
#(
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              slot_active,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data
);
    localparam int unsigned PW = ptr_width(DEPTH);
    localparam int unsigned CW = cnt_width(DEPTH);
    localparam int unsigned EW = ADDR_W + DATA_W;

    logic          push, pop, can_push;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic [EW-1:0] head;

    sbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push_req(st_valid), .slot_active(slot_active),
        .can_push(can_push), .push(push), .pop(pop),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
    );

    sbuf_store #(.DEPTH(DEPTH), .W(EW)) u_store (
        .clk(clk), .we(push), .wr_ptr(wr_ptr), .wdata({st_addr, st_data}),
        .rd_ptr(rd_ptr), .rdata(head)
    );

    assign st_ready  = can_push;
    assign bus_valid = pop;
    assign {bus_addr, bus_data} = head;

    // R3: no send outside the core's slot
    a_r3_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> slot_active);
    // R5: nothing is sent from a queue that was empty at the start of the cycle
    a_r5_no_write_through: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !bus_valid);
    // R6: whenever a send frees an entry the core may issue
    a_r6_ready_on_send: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> st_ready);
    // R2: a stall means the queue is full
    a_r2_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        !st_ready |-> (count == CW'(DEPTH)));
endmodule

// File: tb/sim_sbuf_tdma_drain.sv
module sim_sbuf_tdma_drain;
    localparam int WIN = 8;
    localparam int SLOT = 2;

    logic clk = 0, rst_n = 0;
    logic st_valid = 0, slot_en = 1;
    logic [31:0] st_addr = '0, st_data = '0;
    logic st_ready, bus_valid, slot_active;
    logic [31:0] bus_addr, bus_data;
    int cyc = 0;
    int checks = 0, errors = 0, bad_slot = 0;
    int ns = 0;
    int s_cyc [16];
    logic [31:0] s_dat [16];
    logic [31:0] s_adr [16];
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign slot_active = slot_en && ((cyc % WIN) < SLOT);

    sbuf_tdma_drain u0 (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .slot_active(slot_active),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data)
    );

    always @(negedge clk) if (rst_n && bus_valid) begin
        if (!slot_active) bad_slot++;
        if (ns < 16) begin
            s_cyc[ns] = cyc; s_dat[ns] = bus_data; s_adr[ns] = bus_addr;
        end
        ns++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // present one store at the current negedge and wait until accepted
    task automatic put(input logic [31:0] a, input logic [31:0] d, output int acc);
        st_valid = 1; st_addr = a; st_data = d;
        #1;
        while (!st_ready) begin
            @(negedge clk); #1;
        end
        acc = cyc;
    endtask

    // cycle-level model for the three-store trace starting at offset s
    task automatic model(input int s, output int ex [3], output int acc_first);
        int cnt = 0, k = 0, sent = 0, nxt = s;
        int gap [3] = '{0, 4, 1};
        acc_first = s;
        for (int c = s; c < s + 64; c++) begin
            bit pp, ac;
            pp = ((c % WIN) < SLOT) && cnt > 0;
            ac = (k < 3) && (c >= nxt) && ((cnt < 2) || pp);
            if (pp) begin ex[sent] = c; sent++; cnt--; end
            if (ac) begin
                cnt++; k++;
                if (k < 3) nxt = c + gap[k];
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int acc, a0;
        int ex [3];
        int gap [3] = '{0, 4, 1};
        repeat (3) @(negedge clk);
        chk(st_ready === 1'b1, "R1 ready in reset", st_ready, 1);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(st_ready === 1'b1, "R1 ready after reset", st_ready, 1);
        chk(bus_valid === 1'b0, "R1 idle after reset", bus_valid, 0);

        // full-queue stall with the slot held off
        slot_en = 0; ns = 0;
        put(32'h100, 32'h11, acc);
        chk(acc == cyc, "R2 first store accepted at once", acc, cyc);
        @(negedge clk);
        put(32'h104, 32'h22, acc);
        @(negedge clk);
        st_valid = 1; st_addr = 32'h108; st_data = 32'h33; #1;
        chk(st_ready === 1'b0, "R7 third store stalls", st_ready, 0);
        repeat (3) @(negedge clk);
        chk(st_ready === 1'b0, "R6 stall held while full", st_ready, 0);
        chk(ns == 0, "R3 no send with slot off", ns, 0);
        while (cyc % WIN != WIN - 1) @(negedge clk);
        slot_en = 1;
        @(negedge clk); #1;
        chk(st_ready === 1'b1 && bus_valid === 1'b1, "R6 refill on send", st_ready, 1);
        @(negedge clk);
        st_valid = 0;
        repeat (12) @(negedge clk);
        chk(ns == 3, "R4 three sends", ns, 3);
        chk(s_dat[0] == 32'h11 && s_adr[0] == 32'h100, "R4 order 0", s_dat[0], 32'h11);
        chk(s_dat[1] == 32'h22 && s_adr[1] == 32'h104, "R4 order 1", s_dat[1], 32'h22);
        chk(s_dat[2] == 32'h33 && s_adr[2] == 32'h108, "R4 order 2", s_dat[2], 32'h33);
        chk(s_cyc[1] == s_cyc[0] + 1, "R3 back-to-back in slot", s_cyc[1], s_cyc[0] + 1);
        chk(s_cyc[2] == s_cyc[0] + WIN, "R3 wait for next window", s_cyc[2], s_cyc[0] + WIN);

        // injection trace over every start offset
        for (int s = 0; s < WIN; s++) begin
            int mf;
            model(s, ex, mf);
            repeat (WIN) @(negedge clk);
            while (cyc % WIN != s) @(negedge clk);
            ns = 0;
            for (int k = 0; k < 3; k++) begin
                if (k > 0) begin
                    for (int j = 0; j < gap[k]; j++) begin
                        @(negedge clk);
                        if (j < gap[k] - 1) st_valid = 0;
                    end
                end
                put(32'h200 + 32'(s * 16 + k * 4), 32'(s * 16 + k), acc);
                if (k == 0) a0 = acc;
            end
            @(negedge clk); st_valid = 0;
            repeat (24) @(negedge clk);
            chk(ns == 3, "R8 send count", ns, 3);
            for (int k = 0; k < 3; k++) begin
                chk(s_cyc[k] - a0 == ex[k] - mf, "R8 send cycle", s_cyc[k] - a0, ex[k] - mf);
                chk(s_dat[k] == 32'(s * 16 + k), "R4 trace data order", s_dat[k], s * 16 + k);
            end
            chk(s_cyc[0] > a0, "R5 not sent in write cycle", s_cyc[0], a0 + 1);
            if (s == 0) chk(s_cyc[2] - a0 + 1 == 10, "R8 offset 0 span", s_cyc[2] - a0 + 1, 10);
            if (s == 1) chk(s_cyc[2] - a0 + 1 == 16, "R8 offset 1 span", s_cyc[2] - a0 + 1, 16);
        end
        chk(bad_slot == 0, "R3 sends only in slot", bad_slot, 0);
        finish_run();
    end
endmodule